// File: doc/BRIEF.md
# Two-Dimensional Strided Beat Address Generator

This block turns one transfer request into the ordered list of bus beats that cover a rectangular region of memory. A request gives a start address, a row length in bytes (programmed as length minus one), a row count (programmed as count minus one), a row stride and a transfer tag. The block walks the region row by row and offers one beat at a time to a memory-side master as an address and a byte count. When the last beat has been taken, it raises a one-cycle completion pulse that carries the tag back.

Each row starts at the previous row's start plus the stride. The stride is independent of the row length, so rows may be spaced apart or may overlap. Within a row, the beats step by the bus width. Only the last beat of a row may be short. A request whose start address or stride is not aligned to the bus width, or whose row length has bits set in the configured length mask, is refused without issuing any beat. A build parameter selects the single-row variant, in which the row count field is ignored and each request moves exactly one row.

Top module: `stride2d_agen`

## Requirements
- R1: After reset, req_ready is 1 and beat_valid, done and rej are 0.
- R2: The first beat of every row carries that row's start address. Each following beat in the row adds the bus width (2^BUS_LOG2 bytes, 4 by default), and every beat address is aligned to the bus width.
- R3: A row moves exactly req_xlen_m1+1 bytes. Every beat except the last of a row carries the bus width in beat_bytes. The last beat carries the remaining 1 to bus-width bytes.
- R4: With 2D enabled, req_ylen_m1+1 rows are produced, and row r starts at req_addr + r*req_stride.
- R5: beat_row_end is 1 exactly on the last beat of each row. beat_last is 1 exactly on the last beat of the last row.
- R6: While beat_valid is 1 and beat_ready is 0, the offered beat (address, byte count, flags) is held unchanged.
- R7: done is high for exactly one cycle, in the cycle after the handshake of the beat marked beat_last, and evt_id then equals the request's req_id.
- R8: req_ready is 1 only while no transfer is in progress. A req_valid presented during a transfer is ignored and does not change the beats or the tag.
- R9: A request is refused when req_addr or req_stride has any bit below BUS_LOG2 set, or when (req_xlen_m1+1) AND LEN_ALIGN_MASK is nonzero. A refused request produces no beats, and rej pulses for one cycle in the cycle after acceptance, with evt_id equal to its req_id.
- R10: With ENABLE_2D=0, req_ylen_m1 has no effect. A single row of req_xlen_m1+1 bytes is moved and then done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start address of the first row |
| req_xlen_m1 | input | LEN_W | Row length in bytes minus one |
| req_ylen_m1 | input | LEN_W | Row count minus one |
| req_stride | input | ADDR_W | Distance between row start addresses |
| req_id | input | ID_W | Transfer tag |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | Master takes the offered beat |
| beat_addr | output | ADDR_W | Beat address |
| beat_bytes | output | BUS_LOG2+1 | Bytes in this beat |
| beat_row_end | output | 1 | Last beat of a row |
| beat_last | output | 1 | Last beat of the transfer |
| done | output | 1 | One-cycle completion pulse |
| rej | output | 1 | One-cycle refusal pulse |
| evt_id | output | ID_W | Tag belonging to done or rej |

## Verification
On every cycle, the assertions check the following: beat byte counts stay within one to the bus width, beat addresses stay aligned, a stalled beat holds still, done is a single-cycle pulse that follows the final handshake, and a refusal never coincides with a beat or a completion. Only the directed scenarios can show the actual address sequence: row starts that follow the stride, short tail beats, the placement of the row-end flags and the returned tags. The same holds for requests ignored during a busy transfer, refusal on a misaligned address, stride or length, and the single-row build that disregards the row count.

// File: rtl/stride2d_pkg.sv
package stride2d_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/stride2d_check.sv
// Request admission: alignment of start address and stride, length mask.
module stride2d_check #(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int BUS_LOG2       = 2,
  parameter int LEN_ALIGN_MASK = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  xlen_m1,
  output logic              ok
);
  localparam logic [LEN_W:0] LMASK = LEN_ALIGN_MASK[LEN_W:0];

  logic [LEN_W:0] row_bytes;
  logic           addr_ok, stride_ok, len_ok;

  always_comb begin
    row_bytes = {1'b0, xlen_m1} + {{LEN_W{1'b0}}, 1'b1};
    addr_ok   = (addr[BUS_LOG2-1:0] == '0);
    stride_ok = (stride[BUS_LOG2-1:0] == '0);
    len_ok    = ((row_bytes & LMASK) == '0);
    ok        = addr_ok && stride_ok && len_ok;
  end
endmodule

// File: rtl/stride2d_walker.sv
// Row and beat counters: current address, bytes left in row, rows left.
module stride2d_walker #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int BUS_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                adv,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [ADDR_W-1:0]   ld_stride,
  input  logic [LEN_W:0]      ld_bytes,
  input  logic [LEN_W-1:0]    ld_rows,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic [BUS_LOG2:0]   cur_bytes,
  output logic                row_end,
  output logic                final_beat
);
  localparam int               BUS_BYTES = 1 << BUS_LOG2;
  localparam logic [LEN_W:0]   BUS_LEN   = (LEN_W+1)'(BUS_BYTES);
  localparam logic [ADDR_W-1:0] BUS_STEP = ADDR_W'(BUS_BYTES);

  logic [ADDR_W-1:0] row_base_q, cur_q, stride_q;
  logic [LEN_W:0]    row_len_q, left_q;
  logic [LEN_W-1:0]  rows_q;

  always_comb begin
    row_end    = (left_q <= BUS_LEN);
    final_beat = row_end && (rows_q == '0);
    cur_addr   = cur_q;
    cur_bytes  = row_end ? left_q[BUS_LOG2:0] : (BUS_LOG2+1)'(BUS_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base_q <= '0;
      cur_q      <= '0;
      stride_q   <= '0;
      row_len_q  <= '0;
      left_q     <= '0;
      rows_q     <= '0;
    end else if (load) begin
      row_base_q <= ld_addr;
      cur_q      <= ld_addr;
      stride_q   <= ld_stride;
      row_len_q  <= ld_bytes;
      left_q     <= ld_bytes;
      rows_q     <= ld_rows;
    end else if (adv) begin
      if (!row_end) begin
        cur_q  <= cur_q + BUS_STEP;
        left_q <= left_q - BUS_LEN;
      end else if (rows_q != '0) begin
        row_base_q <= row_base_q + stride_q;
        cur_q      <= row_base_q + stride_q;
        left_q     <= row_len_q;
        rows_q     <= rows_q - 1'b1;
      end
    end
  end

  // R3: a row never runs out of bytes before its last beat
  p_left_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    adv && !row_end |=> left_q != '0);
endmodule

// File: rtl/stride2d_agen.sv
module stride2d_agen #(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int ID_W           = 5,
  parameter int BUS_LOG2       = 2,
  parameter int LEN_ALIGN_MASK = 0,
  parameter bit ENABLE_2D      = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_xlen_m1,
  input  logic [LEN_W-1:0]    req_ylen_m1,
  input  logic [ADDR_W-1:0]   req_stride,
  input  logic [ID_W-1:0]     req_id,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic [BUS_LOG2:0]   beat_bytes,
  output logic                beat_row_end,
  output logic                beat_last,
  output logic                done,
  output logic                rej,
  output logic [ID_W-1:0]     evt_id
);
  import stride2d_pkg::*;

  localparam int BUS_BYTES = 1 << BUS_LOG2;

  walk_state_e      state_q;
  logic [ID_W-1:0]  id_q;
  logic             req_ok, accept, load, adv;
  logic [LEN_W:0]   row_bytes;
  logic [LEN_W-1:0] rows_init;

  stride2d_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_LOG2(BUS_LOG2),
    .LEN_ALIGN_MASK(LEN_ALIGN_MASK)
  ) u_check (
    .addr(req_addr), .stride(req_stride), .xlen_m1(req_xlen_m1), .ok(req_ok)
  );

  generate
    if (ENABLE_2D) begin : g_rows
      assign rows_init = req_ylen_m1;
    end else begin : g_flat
      logic unused_rows;
      assign unused_rows = ^req_ylen_m1;
      assign rows_init   = '0;
    end
  endgenerate

  always_comb begin
    req_ready  = (state_q == WALK_IDLE);
    beat_valid = (state_q == WALK_RUN);
    accept     = req_valid && req_ready;
    load       = accept && req_ok;
    adv        = beat_valid && beat_ready;
    row_bytes  = {1'b0, req_xlen_m1} + {{LEN_W{1'b0}}, 1'b1};
  end

  stride2d_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_LOG2(BUS_LOG2)
  ) u_walker (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .ld_addr(req_addr), .ld_stride(req_stride),
    .ld_bytes(row_bytes), .ld_rows(rows_init),
    .cur_addr(beat_addr), .cur_bytes(beat_bytes),
    .row_end(beat_row_end), .final_beat(beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      id_q    <= '0;
      done    <= 1'b0;
      rej     <= 1'b0;
      evt_id  <= '0;
    end else begin
      done <= 1'b0;
      rej  <= 1'b0;
      if (accept) begin
        if (req_ok) begin
          state_q <= WALK_RUN;
          id_q    <= req_id;
        end else begin
          rej    <= 1'b1;
          evt_id <= req_id;
        end
      end
      if (adv && beat_last) begin
        state_q <= WALK_IDLE;
        done    <= 1'b1;
        evt_id  <= id_q;
      end
    end
  end

  // R3: each beat moves between one byte and a full bus word
  p_beat_bytes_r3: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_bytes != '0) && (beat_bytes <= (BUS_LOG2+1)'(BUS_BYTES)));

  // R2: beat addresses stay on bus-width boundaries
  p_beat_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> beat_addr[BUS_LOG2-1:0] == '0);

  // R6: a stalled beat holds
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
      && $stable(beat_bytes) && $stable(beat_last));

  // R7: completion follows the final handshake and lasts one cycle
  p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && beat_last |=> done);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a refusal never overlaps a beat or a completion
  p_rej_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    rej |-> !beat_valid && !done);
endmodule

// File: tb/stride2d_agen_tb.sv
module stride2d_agen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, f_req_valid = 1'b0;
  logic [31:0] req_addr = '0, req_stride = '0;
  logic [15:0] req_xlen_m1 = '0, req_ylen_m1 = '0;
  logic [4:0]  req_id = '0;
  logic        beat_ready = 1'b0;
  logic        f_beat_ready = 1'b1;

  logic        req_ready, beat_valid, beat_row_end, beat_last, done, rej;
  logic [31:0] beat_addr;
  logic [2:0]  beat_bytes;
  logic [4:0]  evt_id;

  logic        f_req_ready, f_beat_valid, f_beat_row_end, f_beat_last, f_done, f_rej;
  logic [31:0] f_beat_addr;
  logic [2:0]  f_beat_bytes;
  logic [4:0]  f_evt_id;

  stride2d_agen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
    .req_stride(req_stride), .req_id(req_id), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_bytes(beat_bytes),
    .beat_row_end(beat_row_end), .beat_last(beat_last), .done(done),
    .rej(rej), .evt_id(evt_id)
  );

  stride2d_agen #(.LEN_ALIGN_MASK(1), .ENABLE_2D(1'b0)) u_dut_flat (
    .clk(clk), .rst(rst), .req_valid(f_req_valid), .req_ready(f_req_ready),
    .req_addr(req_addr), .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
    .req_stride(req_stride), .req_id(req_id), .beat_valid(f_beat_valid),
    .beat_ready(f_beat_ready), .beat_addr(f_beat_addr), .beat_bytes(f_beat_bytes),
    .beat_row_end(f_beat_row_end), .beat_last(f_beat_last), .done(f_done),
    .rej(f_rej), .evt_id(f_evt_id)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    check_eq("R1 req_ready", 64'(req_ready), 64'd1);
    check_eq("R1 beat_valid", 64'(beat_valid), 64'd0);
    check_eq("R1 done", 64'(done), 64'd0);
    check_eq("R1 rej", 64'(rej), 64'd0);
  endtask

  // Runs one 2D transfer on u_dut and checks every beat against the model.
  task automatic t_xfer(input logic [31:0] addr, input logic [15:0] xm1,
                        input logic [15:0] ym1, input logic [31:0] stride,
                        input logic [4:0] id, input bit stall, input bit poke);
    @(negedge clk);
    req_addr = addr; req_xlen_m1 = xm1; req_ylen_m1 = ym1;
    req_stride = stride; req_id = id; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R8 ready low while busy", 64'(req_ready), 64'd0);
    for (int r = 0; r <= int'(ym1); r++) begin
      int rem = int'(xm1) + 1;
      int k = 0;
      while (rem > 0) begin
        logic [31:0] ea;
        int nb;
        ea = addr + 32'(r) * stride + 32'(k * BUS);
        nb = (rem > BUS) ? BUS : rem;
        if (stall) begin
          beat_ready = 1'b0;
          if (poke) begin
            req_valid = 1'b1; req_addr = 32'hDEAD0000; req_id = ~id;
          end
          @(negedge clk);
          req_valid = 1'b0;
          check_eq("R6 held valid", 64'(beat_valid), 64'd1);
          check_eq("R6 held addr", 64'(beat_addr), 64'(ea));
          check_eq("R6 held bytes", 64'(beat_bytes), 64'(nb));
        end
        check_eq("R2 beat valid", 64'(beat_valid), 64'd1);
        if (k == 0) check_eq("R4 row start addr", 64'(beat_addr), 64'(ea));
        else        check_eq("R2 beat addr", 64'(beat_addr), 64'(ea));
        check_eq("R3 beat bytes", 64'(beat_bytes), 64'(nb));
        check_eq("R5 row end", 64'(beat_row_end), 64'(rem <= BUS));
        check_eq("R5 last", 64'(beat_last), 64'((rem <= BUS) && (r == int'(ym1))));
        beat_ready = 1'b1;
        @(negedge clk);
        rem -= nb;
        k++;
      end
    end
    beat_ready = 1'b0;
    check_eq("R7 done", 64'(done), 64'd1);
    check_eq("R7 id", 64'(evt_id), 64'(id));
    check_eq("R8 no extra beat", 64'(beat_valid), 64'd0);
    @(negedge clk);
    check_eq("R7 done one cycle", 64'(done), 64'd0);
    check_eq("R8 idle after", 64'(beat_valid), 64'd0);
  endtask

  task automatic t_reject(input logic [31:0] addr, input logic [31:0] stride,
                          input logic [4:0] id);
    @(negedge clk);
    req_addr = addr; req_stride = stride; req_xlen_m1 = 16'd7;
    req_ylen_m1 = 16'd1; req_id = id; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R9 rej", 64'(rej), 64'd1);
    check_eq("R9 rej id", 64'(evt_id), 64'(id));
    check_eq("R9 no beat", 64'(beat_valid), 64'd0);
    @(negedge clk);
    check_eq("R9 rej one cycle", 64'(rej), 64'd0);
    check_eq("R9 still no beat", 64'(beat_valid), 64'd0);
  endtask

  task automatic t_flat();
    int beats = 0;
    int bytes = 0;
    bit seen = 1'b0;
    @(negedge clk);
    req_addr = 32'h200; req_stride = 32'h40; req_xlen_m1 = 16'd9;
    req_ylen_m1 = 16'd3; req_id = 5'd7; f_req_valid = 1'b1;
    @(negedge clk);
    f_req_valid = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (f_beat_valid) begin
        beats++;
        bytes += int'(f_beat_bytes);
      end
      if (f_done) begin
        seen = 1'b1;
        check_eq("R10 done id", 64'(f_evt_id), 64'd7);
      end else @(negedge clk);
    end
    check_eq("R10 done seen", 64'(seen), 64'd1);
    check_eq("R10 bytes one row", 64'(bytes), 64'd10);
    check_eq("R10 beats", 64'(beats), 64'd3);
    // length 5 bytes violates mask 1
    @(negedge clk);
    req_xlen_m1 = 16'd4; req_id = 5'd9; f_req_valid = 1'b1;
    @(negedge clk);
    f_req_valid = 1'b0;
    check_eq("R9 length rej", 64'(f_rej), 64'd1);
    check_eq("R9 length rej id", 64'(f_evt_id), 64'd9);
    check_eq("R9 length no beat", 64'(f_beat_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_xfer(32'h1000, 16'd15, 16'd0, 32'h0, 5'd3, 1'b0, 1'b0);
    t_xfer(32'h100, 16'd9, 16'd2, 32'h40, 5'd12, 1'b1, 1'b1);
    t_xfer(32'h80, 16'd2, 16'd1, 32'h8, 5'd30, 1'b0, 1'b0);
    t_xfer(32'h44, 16'd0, 16'd0, 32'h0, 5'd1, 1'b1, 1'b0);
    t_xfer(32'h300, 16'd7, 16'd2, 32'h4, 5'd17, 1'b0, 1'b0);
    t_reject(32'h102, 32'h40, 5'd5);
    t_reject(32'h100, 32'h6, 5'd6);
    t_flat();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule